// File: doc/BRIEF.md
# Cascadable Sequential Configuration Memory

This block is a read-only store that streams a fixed image to a configurable device downstream. The image is built at elaboration time from a seed parameter. A select input and an output-enable input gate the block. A shared configuration clock steps it through the image one unit at a time. A mode input picks the unit:

- one bit per clock on data lane 0, most significant bit of each byte first, or
- one whole byte per clock on all eight lanes.

The block does not contain pad tristates. Each data lane has a drive-enable output, and a lane that is not driven reads as zero. The drive enables can feed the pad ring, or an OR-combined shared bus inside the chip.

Several instances can be chained into one longer stream. All instances share the clock and the data lines. The handoff output of one instance selects the next instance. When an instance has presented its last unit, it raises the handoff, releases the data lines and holds its pointer at the end.

Top module: `cfg_stream_mem`

## Requirements
- R1: While `sel_i` or `oe_i` is low, or the contents are exhausted, `data_en_o` is 8'h00 and `data_o` is 8'h00.
- R2: Parallel mode (`par_mode_i`=1), driving: `data_en_o` is 8'hFF and `data_o` is the byte at the current byte address. The byte at address i is (SEED + 29*i) mod 256.
- R3: Serial mode (`par_mode_i`=0), driving: `data_en_o` is 8'h01 and `data_o[7:1]` is zero. `data_o[0]` carries the current bit. Bits go out from bit 7 down to bit 0 of each byte, then on to the next address.
- R4: Each rising clock edge with `sel_i` high and `rst_n` high advances the pointer by one unit (a bit or a byte), whatever the value of `oe_i`. The new unit appears on the outputs after that edge.
- R5: A rising edge with `rst_n` low or `sel_i` low returns the pointer to address zero and clears the exhausted state.
- R6: The edge that consumes the last unit of the contents sets the exhausted state. From then on the pointer neither wraps nor advances, and the outputs stay released until a rewind under R5.
- R7: `next_sel_o` is high exactly while the exhausted state is set and `sel_i` is high. It drops in the same cycle as `sel_i`.
- R8: When two instances are chained, with the first one's `next_sel_o` driving the second one's `sel_i`, they give one stream. It holds the first image followed directly by the second. No cycle is idle and no lane is driven by both instances at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; the pointer steps on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read pointer |
| sel_i | input | 1 | Device select; low rewinds the pointer |
| oe_i | input | 1 | Output enable for the data lanes |
| par_mode_i | input | 1 | 1 = byte per clock, 0 = bit per clock on lane 0 |
| data_o | output | 8 | Data lanes, zero where not driven |
| data_en_o | output | 8 | Per-lane drive enable |
| next_sel_o | output | 1 | Handoff select for the next device in the chain |

## Verification
A two-device chain is run end to end in both modes. The byte-wide run shows that the addresses step and that the handoff falls on the byte boundary. The bit-wide run shows the bit order inside each byte and the lane masking. Short patterns separate the control paths from one another:

- output enable held low while the clock runs shows that pointer motion does not depend on the output gate;
- a one-cycle deselect in mid-stream shows the rewind, and a mid-stream reset shows the same rewind from the reset path;
- extra clocks after the end of the image show that the pointer stops and does not wrap;
- dropping select at the end shows that the handoff falls in the same cycle.

// File: rtl/cfg_stream_pkg.sv
// Package: shared constants and the image generator for the configuration
// stream memory. Assumes byte-wide storage.
package cfg_stream_pkg;

    localparam int UNIT_W     = 8;
    localparam int BIT_IDX_W  = 3;
    localparam int IMAGE_STEP = 29;

    // Compute the stored byte at a given address from the seed.
    function automatic logic [UNIT_W-1:0] image_byte(input logic [UNIT_W-1:0] seed,
                                                     input int idx);
        logic [31:0] acc;
        acc = 32'(seed) + 32'(idx) * 32'(IMAGE_STEP);
        return acc[UNIT_W-1:0];
    endfunction

endpackage

// File: rtl/cfg_image_rom.sv
// Module: constant image store with one combinational read port.
// Assumes DEPTH >= 2 and an address that stays below DEPTH.
module cfg_image_rom #(
    parameter int          DEPTH = 16,
    parameter logic [7:0]  SEED  = 8'h5A,
    localparam int         AW    = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr_i,
    output logic [7:0]    byte_o
);
    import cfg_stream_pkg::*;

    logic [UNIT_W-1:0] table_w [DEPTH];

    // Build one constant entry per address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign table_w[g] = image_byte(SEED, g);
    end

    // Read the addressed entry.
    assign byte_o = table_w[addr_i];

endmodule

// File: rtl/cfg_read_ptr.sv
// Module: read pointer in bit units. The upper bits address the byte and the
// low three bits select the bit inside it. Steps by one bit in serial mode and
// by one byte in parallel mode. Stops at the last unit and flags exhaustion.
// Assumes the mode input is static during a stream.
module cfg_read_ptr #(
    parameter int  DEPTH   = 16,
    localparam int BYTE_AW = $clog2(DEPTH),
    localparam int PTR_W   = BYTE_AW + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             par_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             done_o
);
    localparam logic [BYTE_AW-1:0] LAST_BYTE = BYTE_AW'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic             done_q;
    logic             at_last_w;
    logic [PTR_W-1:0] step_w;

    // Detect the final unit of the image for the current mode.
    always_comb begin
        if (par_i) begin
            at_last_w = (ptr_q[PTR_W-1:3] == LAST_BYTE);
        end else begin
            at_last_w = (ptr_q == {LAST_BYTE, 3'b111});
        end
    end

    // Form the next pointer value for the current mode.
    always_comb begin
        if (par_i) begin
            step_w = {ptr_q[PTR_W-1:3] + 1'b1, 3'b000};
        end else begin
            step_w = ptr_q + 1'b1;
        end
    end

    // Rewind, advance or hold the pointer and the exhausted flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_i) begin
            ptr_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (at_last_w) begin
                done_q <= 1'b1;
            end else begin
                ptr_q <= step_w;
            end
        end
    end

    assign ptr_o  = ptr_q;
    assign done_o = done_q;

endmodule

// File: rtl/cfg_out_gate.sv
// Module: output gating and lane selection. Drives all lanes in parallel mode
// or lane 0 alone in serial mode, and releases every lane when unselected,
// disabled or exhausted. Undriven lanes read as zero.
module cfg_out_gate (
    input  logic       sel_i,
    input  logic       oe_i,
    input  logic       done_i,
    input  logic       par_i,
    input  logic [7:0] byte_i,
    input  logic [2:0] bit_idx_i,
    output logic [7:0] data_o,
    output logic [7:0] data_en_o
);
    logic drive_w;
    logic bit_w;

    // Pick the current bit, most significant first.
    assign bit_w = byte_i[3'd7 - bit_idx_i];

    // Decide whether this device owns the shared lanes.
    assign drive_w = sel_i && oe_i && !done_i;

    // Place the unit on the lanes and raise the matching drive enables.
    always_comb begin
        data_o    = 8'h00;
        data_en_o = 8'h00;
        if (drive_w) begin
            if (par_i) begin
                data_o    = byte_i;
                data_en_o = 8'hFF;
            end else begin
                data_o    = {7'b0, bit_w};
                data_en_o = 8'h01;
            end
        end
    end

endmodule

// File: rtl/cfg_stream_mem.sv
// Module: top of the cascadable configuration stream memory. Combines the
// image store, the read pointer and the output gate, and derives the handoff
// select for the next device. Assumes DEPTH >= 2 and one shared clock.
module cfg_stream_mem #(
    parameter int         DEPTH = 16,
    parameter logic [7:0] SEED  = 8'h5A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic       oe_i,
    input  logic       par_mode_i,
    output logic [7:0] data_o,
    output logic [7:0] data_en_o,
    output logic       next_sel_o
);
    localparam int BYTE_AW = $clog2(DEPTH);
    localparam int PTR_W   = BYTE_AW + 3;

    logic [PTR_W-1:0] ptr_w;
    logic             done_w;
    logic [7:0]       byte_w;

    // Pointer: holds the position in bit units.
    cfg_read_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel_i),
        .par_i  (par_mode_i),
        .ptr_o  (ptr_w),
        .done_o (done_w)
    );

    // Image store: addressed by the byte part of the pointer.
    cfg_image_rom #(.DEPTH(DEPTH), .SEED(SEED)) u_rom (
        .addr_i (ptr_w[PTR_W-1:3]),
        .byte_o (byte_w)
    );

    // Output gate: lane selection and release.
    cfg_out_gate u_gate (
        .sel_i     (sel_i),
        .oe_i      (oe_i),
        .done_i    (done_w),
        .par_i     (par_mode_i),
        .byte_i    (byte_w),
        .bit_idx_i (ptr_w[2:0]),
        .data_o    (data_o),
        .data_en_o (data_en_o)
    );

    // Handoff: selects the next device once this one is exhausted.
    assign next_sel_o = done_w && sel_i;

endmodule

// File: rtl/cfg_stream_mem_chk.sv
// Module: property checker for cfg_stream_mem, attached by bind.
module cfg_stream_mem_chk #(
    parameter int PTR_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_i,
    input logic             oe_i,
    input logic             par_mode_i,
    input logic [7:0]       data_o,
    input logic [7:0]       data_en_o,
    input logic             next_sel_o,
    input logic [PTR_W-1:0] ptr_i
);
    // R1
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && oe_i) |-> (data_en_o == 8'h00 && data_o == 8'h00));

    // R2
    par_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && oe_i && par_mode_i && !next_sel_o) |-> data_en_o == 8'hFF);

    // R3
    ser_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && oe_i && !par_mode_i && !next_sel_o) |->
            (data_en_o == 8'h01 && data_o[7:1] == 7'd0));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !next_sel_o) |=> (ptr_i != $past(ptr_i) || next_sel_o || !sel_i));

    // R5
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> ptr_i == '0);

    // R6
    exhausted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_sel_o |-> data_en_o == 8'h00);

    // R6
    handoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && next_sel_o) |=> (next_sel_o || !sel_i));

    // R7
    handoff_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_sel_o |-> sel_i);

endmodule

bind cfg_stream_mem cfg_stream_mem_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .oe_i       (oe_i),
    .par_mode_i (par_mode_i),
    .data_o     (data_o),
    .data_en_o  (data_en_o),
    .next_sel_o (next_sel_o),
    .ptr_i      (ptr_w)
);

// File: tb/cfg_stream_mem_test.sv
module cfg_stream_mem_test;

    localparam int         A_DEPTH = 4;
    localparam logic [7:0] A_SEED  = 8'h5A;
    localparam int         B_DEPTH = 3;
    localparam logic [7:0] B_SEED  = 8'hC3;

    logic       clk = 1'b0;
    logic       rst_n, sel, oe, par;
    logic [7:0] a_d, a_en, b_d, b_en;
    logic       a_next, b_next;

    int checks = 0;
    int fails = 0;
    int conflicts = 0;
    int gaps = 0;
    int pops = 0;
    logic mon_on = 1'b0;
    logic [15:0] exp_q [$];

    always #4 clk = ~clk;

    cfg_stream_mem #(.DEPTH(A_DEPTH), .SEED(A_SEED)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .oe_i(oe), .par_mode_i(par),
        .data_o(a_d), .data_en_o(a_en), .next_sel_o(a_next));

    cfg_stream_mem #(.DEPTH(B_DEPTH), .SEED(B_SEED)) uut_next (
        .clk(clk), .rst_n(rst_n), .sel_i(a_next), .oe_i(oe), .par_mode_i(par),
        .data_o(b_d), .data_en_o(b_en), .next_sel_o(b_next));

    function automatic logic [7:0] model_byte(logic [7:0] seed, int i);
        return 8'((int'(seed) + 29 * i) % 256);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: pushes the expected chain stream, then runs the chain.
    task automatic run_chain(input logic mode);
        @(negedge clk);
        sel = 1'b0;
        mon_on = 1'b0;
        @(negedge clk);
        par = mode;
        exp_q.delete();
        pops = 0;
        for (int i = 0; i < A_DEPTH + B_DEPTH; i++) begin
            logic [7:0] v;
            v = (i < A_DEPTH) ? model_byte(A_SEED, i) : model_byte(B_SEED, i - A_DEPTH);
            if (mode) exp_q.push_back({8'hFF, v});
            else for (int b = 7; b >= 0; b--) exp_q.push_back({8'h01, 7'b0, v[b]});
        end
        sel = 1'b1;
        mon_on = 1'b1;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            #2;
            if (b_next) break;
        end
        mon_on = 1'b0;
        // R8: whole stream consumed
        check(exp_q.size() == 0 && b_next, "R8 stream length",
              32'(pops), 32'(mode ? A_DEPTH + B_DEPTH : 8 * (A_DEPTH + B_DEPTH)));
    endtask

    // Monitor: pops and compares each unit presented on the shared lanes.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on) begin
                logic [7:0] ben, bd;
                if ((a_en & b_en) != 8'h00) conflicts++;
                ben = a_en | b_en;
                bd = (a_d & a_en) | (b_d & b_en);
                if (ben != 8'h00) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8 extra unit", {16'h0, ben, bd}, 32'h0);
                    end else begin
                        logic [15:0] e;
                        e = exp_q.pop_front();
                        pops++;
                        // R2 R3: lane mask and unit value
                        check({ben, bd} == e, par ? "R2 byte" : "R3 bit",
                              {16'h0, ben, bd}, {16'h0, e});
                    end
                end else if (!b_next) begin
                    gaps++;
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sel = 1'b1; oe = 1'b1; par = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R5: reset holds pointer at zero while selected
        check(a_d == model_byte(A_SEED, 0), "R5 reset addr", 32'(a_d), 32'(model_byte(A_SEED, 0)));
        check(a_next == 1'b0, "R7 reset handoff", 32'(a_next), 32'd0);
        check(a_en == 8'hFF, "R2 reset lanes", 32'(a_en), 32'hFF);

        @(negedge clk);
        rst_n = 1'b1;
        oe = 1'b0;
        #1;
        // R1: output enable low releases lanes
        check(a_en == 8'h00 && a_d == 8'h00, "R1 oe low", {a_en, a_d}, 32'h0);
        repeat (2) @(negedge clk);
        oe = 1'b1;
        #1;
        // R4: two edges advanced the pointer with oe low
        check(a_d == model_byte(A_SEED, 2), "R4 advance", 32'(a_d), 32'(model_byte(A_SEED, 2)));

        @(negedge clk);
        sel = 1'b0;
        #1;
        check(a_en == 8'h00, "R1 sel low", 32'(a_en), 32'h0);
        @(negedge clk);
        sel = 1'b1;
        #1;
        // R5: deselect rewound the pointer
        check(a_d == model_byte(A_SEED, 0), "R5 sel rewind", 32'(a_d), 32'(model_byte(A_SEED, 0)));

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R5: reset in mid-stream rewound the pointer
        check(a_d == model_byte(A_SEED, 0), "R5 reset rewind", 32'(a_d), 32'(model_byte(A_SEED, 0)));

        run_chain(1'b1);
        run_chain(1'b0);

        // R6: exhausted device stays released and does not wrap
        check(a_next && a_en == 8'h00, "R6 exhausted", {a_next, a_en}, 32'h100);
        repeat (5) @(negedge clk);
        #1;
        check(a_next && a_en == 8'h00 && b_en == 8'h00, "R6 no wrap",
              {b_en, a_en, 7'b0, a_next}, 32'h1);
        @(negedge clk);
        sel = 1'b0;
        #1;
        // R7: handoff drops in the same cycle as select
        check(a_next == 1'b0, "R7 handoff drop", 32'(a_next), 32'd0);
        // R8: no double drive and no idle cycle
        check(conflicts == 0, "R8 contention", 32'(conflicts), 32'd0);
        check(gaps == 0, "R8 gap", 32'(gaps), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule